// File: doc/BRIEF.md
# Flash ECC Syndrome Corrector

This block takes two 22-bit Hamming check words for a 256-byte chunk of flash data, one freshly computed over the data read back and one read from the spare area, and decides what went wrong. Each check word arrives as three bytes in little-endian order. The block places the result in one of four classes: clean, a flipped bit inside the check word itself, a single flipped data bit that can be repaired, or damage beyond repair. For a repairable error it gives the position of the bad bit as a byte index and a bit-within-byte index. It also pulses a strobe so that the caller can repair that byte in its buffer.

A byte handed to the read-modify-write port comes back with the failing bit inverted while the latest result is repairable. In all other cases it comes back unchanged. In 512-byte page mode one start handles both halves of the page. The second half is classified one cycle after the first, and its byte index carries the 256 offset. The final fail flag is the OR of both halves. Check-word generation is done elsewhere.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: Each 24-bit code input holds byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. Only bits 21:0 take part, so a difference confined to bits 23:22 is classified as clean.
- R2: If the two 22-bit words are equal, or if either word is all zero, the class is 0 (clean) and fail is 0.
- R3: If the XOR of the two words has exactly one bit set, the class is 1 (check-word error), fail is 1 and correctEn stays low.
- R4: The class is 2 (repairable) with fail 0 when the XOR has exactly eleven ones and its bits 10:0 are the bitwise complement of its bits 21:11.
- R5: For class 2, bitIdx equals XOR bits 2:0, byteIdx[7:0] equals XOR bits 10:3, and correctEn pulses for one cycle together with resultValid. For every other class, byteIdx and bitIdx are zero.
- R6: Any other nonzero pattern of the XOR, including eleven ones whose two halves are not complements, gives class 3 (uncorrectable) and fail 1.
- R7: Inputs are sampled on the clock edge where start is high. resultValid, done and the result fields appear after the next edge, that is two edges after start. resultValid and done are single-cycle pulses.
- R8: With pageMode512 high at start, the first half uses calcCode0/storedCode0 and the second half uses calcCode1/storedCode1. The second result follows one cycle after the first, with byteIdx[8] set to 1. done pulses only with the second result, and fail at done is the OR of the failures of both halves.
- R9: While the held class is 2, rmwByteOut equals rmwByteIn with bit bitIdx inverted. Otherwise rmwByteOut equals rmwByteIn.
- R10: A start raised while an earlier request is still in its first stage, or while the second half of a 512-byte request is still pending, is ignored.
- R11: After reset, resultValid, done, correctEn and fail are 0 and the class is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check; codes sampled on this edge |
| pageMode512 | input | 1 | Process two 256-byte halves |
| calcCode0 | input | 24 | Computed check bytes, first half |
| storedCode0 | input | 24 | Stored check bytes, first half |
| calcCode1 | input | 24 | Computed check bytes, second half |
| storedCode1 | input | 24 | Stored check bytes, second half |
| rmwByteIn | input | 8 | Data byte to repair |
| resultValid | output | 1 | One result (per half) is on the outputs |
| done | output | 1 | Last result of the request |
| eccClass | output | 2 | 0 clean, 1 check-word bit, 2 repairable, 3 uncorrectable |
| fail | output | 1 | Failure flag, ORed over halves, valid with done |
| byteIdx | output | 9 | Failing byte within the page |
| bitIdx | output | 3 | Failing bit within the byte |
| correctEn | output | 1 | Pulses with a repairable result |
| rmwByteOut | output | 8 | rmwByteIn with the failing bit inverted |

## Verification
A single-half result is due two rising edges after the edge that samples start. In 512-byte mode the second-half result and done are due one edge after that. The bench raises start on a falling edge and counts falling edges from that point. It confirms that resultValid is still low after one edge, then reads every result field at the falling edge that follows the due edge, so that no value is read at a clock edge. The read-modify-write output is combinational from the held result, so the bench checks it on a later falling edge after changing rmwByteIn. Pulse widths are confirmed by checking that done is low again one cycle later.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int PORT_W    = 24;              // three code bytes
  localparam int CODE_W    = 22;              // meaningful code bits
  localparam int HALF_W    = CODE_W / 2;      // parity / complement halves
  localparam int BIT_W     = 3;               // bit-within-byte index
  localparam int DATA_W    = 1 << BIT_W;      // data byte width
  localparam int BYTE_W    = HALF_W - BIT_W;  // byte-within-chunk index
  localparam int PIDX_W    = BYTE_W + 1;      // byte-within-page index
  localparam int CNT_W     = $clog2(PORT_W + 1);
  localparam logic [PORT_W-1:0] CODE_MASK = PORT_W'((1 << CODE_W) - 1);

  typedef enum logic [1:0] {
    CLS_CLEAN   = 2'd0,
    CLS_ECC_BIT = 2'd1,
    CLS_FIXABLE = 2'd2,
    CLS_BROKEN  = 2'd3
  } eccClass_t;

  typedef struct packed {
    logic loadFirst;   // capture first-half codes, hold second-half codes
    logic loadSecond;  // move held codes into the stage
    logic emit;        // register a classification
    logic emitChunk;   // which half is being emitted
  } ctrlStrobe_t;
endpackage

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        pageMode512,
  output ctrlStrobe_t strobe,
  output logic        resultValid,
  output logic        done
);
  logic stageValid;
  logic stageLast;
  logic stageChunk;
  logic secondPending;
  logic accept;

  assign accept = start && !stageValid && !secondPending;

  always_comb begin
    strobe.loadFirst  = accept;
    strobe.loadSecond = secondPending;
    strobe.emit       = stageValid;
    strobe.emitChunk  = stageChunk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid    <= 1'b0;
      stageLast     <= 1'b0;
      stageChunk    <= 1'b0;
      secondPending <= 1'b0;
      resultValid   <= 1'b0;
      done          <= 1'b0;
    end else begin
      stageValid    <= accept || secondPending;
      stageChunk    <= secondPending;
      stageLast     <= secondPending || (accept && !pageMode512);
      secondPending <= accept && pageMode512;
      resultValid   <= stageValid;
      done          <= stageValid && stageLast;
    end
  end
endmodule

// File: rtl/ecc_fix_datapath.sv
module ecc_fix_datapath
  import ecc_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [PORT_W-1:0] calcCode0,
  input  logic [PORT_W-1:0] storedCode0,
  input  logic [PORT_W-1:0] calcCode1,
  input  logic [PORT_W-1:0] storedCode1,
  input  logic [DATA_W-1:0] rmwByteIn,
  output eccClass_t         resClass,
  output logic              failFlag,
  output logic [PIDX_W-1:0] byteIdx,
  output logic [BIT_W-1:0]  bitIdx,
  output logic              correctEn,
  output logic [DATA_W-1:0] rmwByteOut
);
  logic [PORT_W-1:0] stCalc, stStored, holdCalc, holdStored;
  logic [PORT_W-1:0] calcMasked, storedMasked, syn;
  logic [HALF_W-1:0] pairMix;
  logic [CNT_W-1:0]  ones;
  eccClass_t         cls;
  logic              clsFail;

  // stage 1: capture codes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stCalc     <= '0;
      stStored   <= '0;
      holdCalc   <= '0;
      holdStored <= '0;
    end else if (strobe.loadFirst) begin
      stCalc     <= calcCode0;
      stStored   <= storedCode0;
      holdCalc   <= calcCode1;
      holdStored <= storedCode1;
    end else if (strobe.loadSecond) begin
      stCalc   <= holdCalc;
      stStored <= holdStored;
    end
  end

  // stage 2: syndrome, popcount, classification
  assign calcMasked   = stCalc & CODE_MASK;
  assign storedMasked = stStored & CODE_MASK;
  assign syn          = calcMasked ^ storedMasked;
  assign pairMix      = (calcMasked[HALF_W-1:0] ^ calcMasked[CODE_W-1:HALF_W])
                      ^ (storedMasked[HALF_W-1:0] ^ storedMasked[CODE_W-1:HALF_W]);

  always_comb begin
    ones = '0;
    for (int i = 0; i < PORT_W; i++) begin
      ones = ones + CNT_W'(syn[i]);
    end
  end

  always_comb begin
    if (syn == '0 || calcMasked == '0 || storedMasked == '0) begin
      cls = CLS_CLEAN;
    end else if (ones == CNT_W'(1)) begin
      cls = CLS_ECC_BIT;
    end else if (ones == CNT_W'(HALF_W) && pairMix == {HALF_W{1'b1}}) begin
      cls = CLS_FIXABLE;
    end else begin
      cls = CLS_BROKEN;
    end
    clsFail = (cls == CLS_ECC_BIT) || (cls == CLS_BROKEN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resClass  <= CLS_CLEAN;
      failFlag  <= 1'b0;
      byteIdx   <= '0;
      bitIdx    <= '0;
      correctEn <= 1'b0;
    end else if (strobe.emit) begin
      resClass  <= cls;
      failFlag  <= strobe.emitChunk ? (failFlag || clsFail) : clsFail;
      correctEn <= (cls == CLS_FIXABLE);
      if (cls == CLS_FIXABLE) begin
        byteIdx <= {strobe.emitChunk, syn[HALF_W-1:BIT_W]};
        bitIdx  <= syn[BIT_W-1:0];
      end else begin
        byteIdx <= '0;
        bitIdx  <= '0;
      end
    end else begin
      correctEn <= 1'b0;
    end
  end

  // read-modify-write repair of one byte
  always_comb begin
    if (resClass == CLS_FIXABLE) begin
      rmwByteOut = rmwByteIn ^ (DATA_W'(1) << bitIdx);
    end else begin
      rmwByteOut = rmwByteIn;
    end
  end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import ecc_fix_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        pageMode512,
  input  logic [23:0] calcCode0,
  input  logic [23:0] storedCode0,
  input  logic [23:0] calcCode1,
  input  logic [23:0] storedCode1,
  input  logic [7:0]  rmwByteIn,
  output logic        resultValid,
  output logic        done,
  output logic [1:0]  eccClass,
  output logic        fail,
  output logic [8:0]  byteIdx,
  output logic [2:0]  bitIdx,
  output logic        correctEn,
  output logic [7:0]  rmwByteOut
);
  ctrlStrobe_t strobe;
  eccClass_t   resClass;

  ecc_fix_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .pageMode512 (pageMode512),
    .strobe      (strobe),
    .resultValid (resultValid),
    .done        (done)
  );

  ecc_fix_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .calcCode0   (calcCode0),
    .storedCode0 (storedCode0),
    .calcCode1   (calcCode1),
    .storedCode1 (storedCode1),
    .rmwByteIn   (rmwByteIn),
    .resClass    (resClass),
    .failFlag    (fail),
    .byteIdx     (byteIdx),
    .bitIdx      (bitIdx),
    .correctEn   (correctEn),
    .rmwByteOut  (rmwByteOut)
  );

  assign eccClass = resClass;
endmodule

// File: rtl/ecc_syndrome_fix_chk.sv
module ecc_syndrome_fix_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       resultValid,
  input logic       done,
  input logic [1:0] eccClass,
  input logic       fail,
  input logic       correctEn,
  input logic [7:0] rmwByteIn,
  input logic [7:0] rmwByteOut
);
  AST_ECCBIT_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (done && eccClass == 2'd1) |-> fail); // R3

  AST_STROBE_REPAIRABLE: assert property (@(posedge clk) disable iff (!rstN)
    correctEn |-> (resultValid && eccClass == 2'd2)); // R5

  AST_BROKEN_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (done && eccClass == 2'd3) |-> fail); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> resultValid); // R7

  AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ($past(start, 2) || $past(resultValid))); // R7

  AST_SECOND_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !done) |=> (resultValid && done)); // R8

  AST_RMW_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    (eccClass != 2'd2) |-> (rmwByteOut == rmwByteIn)); // R9
endmodule

bind ecc_syndrome_fix ecc_syndrome_fix_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .resultValid (resultValid),
  .done        (done),
  .eccClass    (eccClass),
  .fail        (fail),
  .correctEn   (correctEn),
  .rmwByteIn   (rmwByteIn),
  .rmwByteOut  (rmwByteOut)
);

// File: tb/ecc_syndrome_fix_bench.sv
`timescale 1ns/1ps
module ecc_syndrome_fix_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        pageMode512 = 1'b0;
  logic [23:0] calcCode0 = '0, storedCode0 = '0, calcCode1 = '0, storedCode1 = '0;
  logic [7:0]  rmwByteIn = '0;
  logic        resultValid, done, fail, correctEn;
  logic [1:0]  eccClass;
  logic [8:0]  byteIdx;
  logic [2:0]  bitIdx;
  logic [7:0]  rmwByteOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ecc_syndrome_fix u_ecc_syndrome_fix (
    .clk(clk), .rstN(rstN), .start(start), .pageMode512(pageMode512),
    .calcCode0(calcCode0), .storedCode0(storedCode0),
    .calcCode1(calcCode1), .storedCode1(storedCode1),
    .rmwByteIn(rmwByteIn), .resultValid(resultValid), .done(done),
    .eccClass(eccClass), .fail(fail), .byteIdx(byteIdx), .bitIdx(bitIdx),
    .correctEn(correctEn), .rmwByteOut(rmwByteOut)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // 22-bit syndrome of a genuine single data-bit error at byte b, bit k
  function automatic logic [23:0] oneBitSyn(input logic [7:0] b, input logic [2:0] k);
    logic [10:0] lo;
    lo = {b, k};
    return {2'b00, ~lo, lo};
  endfunction

  // one 256-byte check, results checked at their due cycle
  task automatic runSingle(input logic [23:0] c, input logic [23:0] s,
                           input int expCls, input int expFail,
                           input int expByte, input int expBit, input string req);
    @(negedge clk);
    start = 1'b1; pageMode512 = 1'b0; calcCode0 = c; storedCode0 = s;
    @(negedge clk);
    start = 1'b0; calcCode0 = '0; storedCode0 = '0;
    checkEq("R7", "resultValid one edge after start", int'(resultValid), 0);
    @(negedge clk);
    checkEq("R7", "resultValid", int'(resultValid), 1);
    checkEq("R7", "done", int'(done), 1);
    checkEq(req, "eccClass", int'(eccClass), expCls);
    checkEq(req, "fail", int'(fail), expFail);
    checkEq(req, "byteIdx", int'(byteIdx), expByte);
    checkEq(req, "bitIdx", int'(bitIdx), expBit);
    checkEq(req, "correctEn", int'(correctEn), (expCls == 2) ? 1 : 0);
    @(negedge clk);
    checkEq("R7", "done pulse ends", int'(done), 0);
    checkEq("R7", "resultValid pulse ends", int'(resultValid), 0);
  endtask

  task automatic t_reset;
    checkEq("R11", "resultValid", int'(resultValid), 0);
    checkEq("R11", "done", int'(done), 0);
    checkEq("R11", "correctEn", int'(correctEn), 0);
    checkEq("R11", "fail", int'(fail), 0);
    checkEq("R11", "eccClass", int'(eccClass), 0);
  endtask

  task automatic t_clean;
    runSingle(24'h2A5A5A, 24'h2A5A5A, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_zeroWord;
    runSingle(24'h1F00F3, 24'h000000, 0, 0, 0, 0, "R2");
    runSingle(24'h000000, 24'h0C0300, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_highBitsIgnored;
    runSingle(24'hC12345, 24'h012345, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_eccBit;
    runSingle(24'h123456, 24'h123456 ^ 24'h000400, 1, 1, 0, 0, "R3");
  endtask

  task automatic t_fixable;
    runSingle(24'h123456, 24'h123456 ^ oneBitSyn(8'hA5, 3'd3), 2, 0, 'hA5, 3, "R4");
    // R9 repair of bit 3
    rmwByteIn = 8'h00;
    @(negedge clk);
    checkEq("R9", "rmwByteOut flip 0x00", int'(rmwByteOut), 'h08);
    rmwByteIn = 8'hFF;
    @(negedge clk);
    checkEq("R9", "rmwByteOut flip 0xFF", int'(rmwByteOut), 'hF7);
    // R5 index from both code bytes
    runSingle(24'h3F0F01, 24'h3F0F01 ^ oneBitSyn(8'h01, 3'd7), 2, 0, 'h01, 7, "R5");
  endtask

  task automatic t_broken;
    runSingle(24'h123456, 24'h123456 ^ 24'h000003, 3, 1, 0, 0, "R6");
    // eleven ones, halves not complements
    runSingle(24'h123456, 24'h123456 ^ {2'b00, 11'h001, 11'h3FF}, 3, 1, 0, 0, "R6");
    rmwByteIn = 8'h5A;
    @(negedge clk);
    checkEq("R9", "rmwByteOut passthrough", int'(rmwByteOut), 'h5A);
  endtask

  task automatic t_page512Fix;
    @(negedge clk);
    start = 1'b1; pageMode512 = 1'b1;
    calcCode0 = 24'h0F0F0F; storedCode0 = 24'h0F0F0F;
    calcCode1 = 24'h2B1C0D; storedCode1 = 24'h2B1C0D ^ oneBitSyn(8'h3C, 3'd6);
    @(negedge clk);
    start = 1'b0; pageMode512 = 1'b0;
    calcCode0 = '0; storedCode0 = '0; calcCode1 = '0; storedCode1 = '0;
    @(negedge clk);
    checkEq("R8", "first half resultValid", int'(resultValid), 1);
    checkEq("R8", "first half done low", int'(done), 0);
    checkEq("R8", "first half class", int'(eccClass), 0);
    @(negedge clk);
    checkEq("R8", "second half resultValid", int'(resultValid), 1);
    checkEq("R8", "second half done", int'(done), 1);
    checkEq("R8", "second half class", int'(eccClass), 2);
    checkEq("R8", "second half byteIdx", int'(byteIdx), 'h13C);
    checkEq("R8", "second half bitIdx", int'(bitIdx), 6);
    checkEq("R8", "second half correctEn", int'(correctEn), 1);
    checkEq("R8", "fail OR", int'(fail), 0);
    @(negedge clk);
    checkEq("R8", "done ends", int'(done), 0);
  endtask

  task automatic t_page512Fail;
    @(negedge clk);
    start = 1'b1; pageMode512 = 1'b1;
    calcCode0 = 24'h123456; storedCode0 = 24'h123456 ^ 24'h010000;
    calcCode1 = 24'h00FF00; storedCode1 = 24'h00FF00;
    @(negedge clk);
    start = 1'b0; pageMode512 = 1'b0;
    @(negedge clk);
    checkEq("R8", "first half class", int'(eccClass), 1);
    @(negedge clk);
    checkEq("R8", "done", int'(done), 1);
    checkEq("R8", "second half class", int'(eccClass), 0);
    checkEq("R8", "fail ORed from first half", int'(fail), 1);
  endtask

  task automatic t_busy;
    int doneCount = 0;
    @(negedge clk);
    start = 1'b1; pageMode512 = 1'b0;
    calcCode0 = 24'h111111; storedCode0 = 24'h111111;
    @(negedge clk);
    calcCode0 = 24'h111111; storedCode0 = 24'h111111 ^ 24'h000003;
    @(negedge clk);
    start = 1'b0;
    if (done) doneCount++;
    checkEq("R10", "class of first request", int'(eccClass), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) doneCount++;
    end
    checkEq("R10", "one done for held start", doneCount, 1);
    checkEq("R10", "class unchanged", int'(eccClass), 0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_zeroWord();
    t_highBitsIgnored();
    t_eccBit();
    t_fixable();
    t_broken();
    t_page512Fix();
    t_page512Fail();
    t_busy();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule